// File: doc/BRIEF.md
# Pending Interest Hash Table

This block keeps track of content requests that have been forwarded but not yet answered. Each command carries a 32-bit signature of the content name, which is already hashed outside the block. With it come a 32-bit handle to where the name is stored, a 16-bit bit-vector of the ingress interfaces and a 16-bit nonce. Entries sit in two flop-based sub-tables that form a two-way d-left arrangement. Each sub-table is indexed by its own slice of the signature, and a hit needs the full signature to match.

A request command does one of four things. It inserts a new entry, or it merges its interface into an existing entry, or it is flagged as a loop when its nonce has already been seen, or it reports that the table is full. A data command removes the matching entry and returns that entry's interface set and name handle, or it reports a miss. A 16-bit time counter advances on `tick_i`. Entries lapse a fixed number of ticks after insertion. Lapsed entries behave as absent at once, and a background scrubber clears their storage, one slot per idle cycle.

A build parameter selects how the two sub-tables are probed: both in one cycle, or one after the other. Either way every command takes the same fixed number of cycles, whatever its outcome.

Top module: `pit_table`

## Requirements
- R1: `cmd_ready_o` is high only when no command is in progress. A command is accepted on a rising edge with `cmd_valid_i` and `cmd_ready_o` both high. Ready stays low from that edge until the response is presented, and it is high again in the cycle that `rsp_valid_o` is high.
- R2: For every command, `rsp_valid_o` rises exactly two rising edges after the accepting edge when PARALLEL=1, and three when PARALLEL=0. It stays high for one cycle, with `rsp_code_o` in the range 0 to 5.
- R3: A request (`cmd_op_i`=0) with no live entry of equal signature returns code 0 (inserted). The entry goes to sub-table 0 at index `sig[IDX_W-1:0]` if that bucket holds no live entry. Otherwise it goes to sub-table 1 at index `sig[2*IDX_W-1:IDX_W]`.
- R4: A request that misses while both candidate buckets hold live entries returns code 3 (full), and nothing is stored.
- R5: A request that hits a live entry, and whose nonce is not yet recorded in it, returns code 1 (aggregated). Its interface vector is ORed into the entry and its nonce is recorded.
- R6: Nonces are recorded as a 16-bit set indexed by the XOR of the four nibbles of the nonce. A hit whose folded nonce bit is already set returns code 2 (loop) and leaves the entry unchanged.
- R7: A data command (`cmd_op_i`=1) that hits returns code 4. It presents the entry's accumulated interface set on `rsp_ifc_o` and its stored name handle on `rsp_ptr_o`, and it removes the entry.
- R8: A data command that hits no live entry returns code 5, with `rsp_ifc_o` and `rsp_ptr_o` both zero.
- R9: An entry inserted when the time counter reads t lapses when the counter reaches t+LIFE, compared modulo 2^16 so that it works across wrap. A lapsed entry is treated as absent by both request and data commands.
- R10: A hit needs all 32 signature bits to match. A signature that shares both index slices with a stored entry but differs elsewhere misses.
- R11: After reset `cmd_ready_o` is high, `rsp_valid_o` is low and the table holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advances the time counter by one on each clock where it is high |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_op_i | input | 1 | 0 = request, 1 = data |
| cmd_sig_i | input | 32 | Name signature |
| cmd_ptr_i | input | 32 | Handle to the stored name |
| cmd_ifc_i | input | 16 | Ingress interface bit-vector |
| cmd_nonce_i | input | 16 | Request nonce |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_code_o | output | 3 | 0 inserted, 1 aggregated, 2 loop, 3 full, 4 data hit, 5 data miss |
| rsp_ifc_o | output | 16 | Interface set on a data hit |
| rsp_ptr_o | output | 32 | Name handle on a data hit |

## Verification
The assertions take for granted that commands arrive only through the handshake, and that no second command is accepted while one is in progress. Under that assumption they can link each response to the opcode captured at acceptance, and fix its timing. They also assume `cmd_op_i` is stable while `cmd_valid_i` is high. The stimulus raises valid only after the previous response, so it only ever presents a command when the block is idle. It keeps LIFE well below half the counter range and drives ticks only between commands, so each expiry point falls on a known counter value.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int SIG_W = 32;
  localparam int PTR_W = 32;
  localparam int EXP_W = 16;
  localparam int NL_W  = 16;
  localparam int IFC_W = 16;
  localparam int NIDX_W = $clog2(NL_W);

  typedef struct packed {
    logic             vld;
    logic [SIG_W-1:0] sig;
    logic [PTR_W-1:0] ptr;
    logic [EXP_W-1:0] exp;
    logic [NL_W-1:0]  nonces;
    logic [IFC_W-1:0] ifcs;
  } pit_entry_t;

  typedef enum logic [2:0] {
    RSP_INSERT = 3'd0,
    RSP_AGGR   = 3'd1,
    RSP_LOOP   = 3'd2,
    RSP_FULL   = 3'd3,
    RSP_DHIT   = 3'd4,
    RSP_DMISS  = 3'd5
  } pit_rsp_e;

  // lapsed once now has reached exp, modulo 2^EXP_W
  function automatic logic pit_expired(input logic [EXP_W-1:0] now, input logic [EXP_W-1:0] exp);
    logic [EXP_W-1:0] d;
    d = now - exp;
    return ~d[EXP_W-1];
  endfunction

  function automatic logic [NIDX_W-1:0] pit_fold(input logic [15:0] n);
    return n[3:0] ^ n[7:4] ^ n[11:8] ^ n[15:12];
  endfunction
endpackage

// File: rtl/pit_probe.sv
module pit_probe import pit_pkg::*; (
  input  pit_entry_t       entry_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [EXP_W-1:0] now_i,
  output logic             live_o,
  output logic             hit_o
);
  assign live_o = entry_i.vld & ~pit_expired(now_i, entry_i.exp);
  assign hit_o  = live_o & (entry_i.sig == sig_i);
endmodule

// File: rtl/pit_scrub.sv
module pit_scrub #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (en_i) ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/pit_table.sv
module pit_table import pit_pkg::*; #(
  parameter int IDX_W    = 4,
  parameter int LIFE     = 100,
  parameter bit PARALLEL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic             cmd_op_i,
  input  logic [SIG_W-1:0] cmd_sig_i,
  input  logic [PTR_W-1:0] cmd_ptr_i,
  input  logic [IFC_W-1:0] cmd_ifc_i,
  input  logic [15:0]      cmd_nonce_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_code_o,
  output logic [IFC_W-1:0] rsp_ifc_o,
  output logic [PTR_W-1:0] rsp_ptr_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int WAYS  = 2;
  localparam int SCR_W = IDX_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_P0, ST_EXEC} st_e;

  st_e              state_q;
  logic             op_q;
  logic [SIG_W-1:0] sig_q;
  logic [PTR_W-1:0] ptr_q;
  logic [IFC_W-1:0] ifc_q;
  logic [15:0]      nonce_q;
  logic [EXP_W-1:0] now_q;

  pit_entry_t tbl [WAYS][DEPTH];

  logic             rsp_valid_q;
  pit_rsp_e         rsp_code_q;
  logic [IFC_W-1:0] rsp_ifc_q;
  logic [PTR_W-1:0] rsp_ptr_q;

  logic accept;
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept      = cmd_valid_i & cmd_ready_o;

  // per-way probe
  logic [IDX_W-1:0] idx  [WAYS];
  pit_entry_t       rd   [WAYS];
  logic             live [WAYS];
  logic             hit  [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign idx[w] = sig_q[w*IDX_W +: IDX_W];
    assign rd[w]  = tbl[w][idx[w]];
    pit_probe u_probe (
      .entry_i (rd[w]),
      .sig_i   (sig_q),
      .now_i   (now_q),
      .live_o  (live[w]),
      .hit_o   (hit[w])
    );
  end

  // way-0 result: direct, or held from the first probe cycle
  logic live0_x, hit0_x;
  if (PARALLEL) begin : g_par
    assign live0_x = live[0];
    assign hit0_x  = hit[0];
  end else begin : g_seq
    logic live0_q, hit0_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live0_q <= 1'b0;
        hit0_q  <= 1'b0;
      end else if (state_q == ST_P0) begin
        live0_q <= live[0];
        hit0_q  <= hit[0];
      end
    end
    assign live0_x = live0_q;
    assign hit0_x  = hit0_q;
  end

  // decision
  logic             hit_any;
  logic             wr_en, wr_way;
  logic [IDX_W-1:0] wr_idx;
  pit_entry_t       wr_entry, hit_e, new_e;
  pit_rsp_e         code_c;
  logic [IFC_W-1:0] out_ifc;
  logic [PTR_W-1:0] out_ptr;
  logic [NL_W-1:0]  nbit;

  assign hit_any = hit0_x | hit[1];
  assign hit_e   = hit0_x ? rd[0] : rd[1];
  assign nbit    = NL_W'(1) << pit_fold(nonce_q);

  always_comb begin
    new_e        = '0;
    new_e.vld    = 1'b1;
    new_e.sig    = sig_q;
    new_e.ptr    = ptr_q;
    new_e.exp    = now_q + EXP_W'(LIFE);
    new_e.nonces = nbit;
    new_e.ifcs   = ifc_q;
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_way   = ~hit0_x;
    wr_idx   = hit0_x ? idx[0] : idx[1];
    wr_entry = hit_e;
    code_c   = RSP_DMISS;
    out_ifc  = '0;
    out_ptr  = '0;
    if (!op_q) begin
      if (hit_any) begin
        if (|(hit_e.nonces & nbit)) begin
          code_c = RSP_LOOP;
        end else begin
          code_c          = RSP_AGGR;
          wr_en           = 1'b1;
          wr_entry.ifcs   = hit_e.ifcs | ifc_q;
          wr_entry.nonces = hit_e.nonces | nbit;
        end
      end else if (!live0_x) begin
        code_c   = RSP_INSERT;
        wr_en    = 1'b1;
        wr_way   = 1'b0;
        wr_idx   = idx[0];
        wr_entry = new_e;
      end else if (!live[1]) begin
        code_c   = RSP_INSERT;
        wr_en    = 1'b1;
        wr_way   = 1'b1;
        wr_idx   = idx[1];
        wr_entry = new_e;
      end else begin
        code_c = RSP_FULL;
      end
    end else if (hit_any) begin
      code_c       = RSP_DHIT;
      wr_en        = 1'b1;
      wr_entry.vld = 1'b0;
      out_ifc      = hit_e.ifcs;
      out_ptr      = hit_e.ptr;
    end
  end

  // scrubber
  logic [SCR_W-1:0] scr_ptr;
  logic             scr_way, scr_en, scr_clr;
  logic [IDX_W-1:0] scr_idx;
  pit_entry_t       scr_e;

  assign scr_en  = (state_q == ST_IDLE) & ~accept;
  assign scr_way = scr_ptr[IDX_W];
  assign scr_idx = scr_ptr[IDX_W-1:0];
  assign scr_e   = tbl[scr_way][scr_idx];
  assign scr_clr = scr_en & scr_e.vld & pit_expired(now_q, scr_e.exp);

  pit_scrub #(.CNT_W(SCR_W)) u_scrub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (scr_en),
    .ptr_o  (scr_ptr)
  );

  // control and command capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= 1'b0;
      sig_q   <= '0;
      ptr_q   <= '0;
      ifc_q   <= '0;
      nonce_q <= '0;
      now_q   <= '0;
    end else begin
      if (tick_i) now_q <= now_q + 1'b1;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= PARALLEL ? ST_EXEC : ST_P0;
          op_q    <= cmd_op_i;
          sig_q   <= cmd_sig_i;
          ptr_q   <= cmd_ptr_i;
          ifc_q   <= cmd_ifc_i;
          nonce_q <= cmd_nonce_i;
        end
        ST_P0:   state_q <= ST_EXEC;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // storage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++)
        for (int i = 0; i < DEPTH; i++)
          tbl[w][i] <= '0;
    end else if (state_q == ST_EXEC && wr_en) begin
      tbl[wr_way][wr_idx] <= wr_entry;
    end else if (scr_clr) begin
      tbl[scr_way][scr_idx].vld <= 1'b0;
    end
  end

  // response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_INSERT;
      rsp_ifc_q   <= '0;
      rsp_ptr_q   <= '0;
    end else begin
      rsp_valid_q <= (state_q == ST_EXEC);
      if (state_q == ST_EXEC) begin
        rsp_code_q <= code_c;
        rsp_ifc_q  <= out_ifc;
        rsp_ptr_q  <= out_ptr;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_ifc_o   = rsp_ifc_q;
  assign rsp_ptr_o   = rsp_ptr_q;
endmodule

// File: rtl/pit_table_chk.sv
module pit_table_chk import pit_pkg::*; #(
  parameter bit PARALLEL = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic             cmd_op_i,
  input logic             rsp_valid_o,
  input logic [2:0]       rsp_code_o,
  input logic [IFC_W-1:0] rsp_ifc_o,
  input logic [PTR_W-1:0] rsp_ptr_o
);
  logic acc, op_seen_q;
  assign acc = cmd_valid_i & cmd_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  op_seen_q <= 1'b0;
    else if (acc) op_seen_q <= cmd_op_i;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !cmd_ready_o); // R1
  AST_READY_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> cmd_ready_o); // R1
  AST_RSP_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!cmd_ready_o)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R2
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_code_o <= 3'd5)); // R2

  if (PARALLEL) begin : g_lat_par
    AST_FIXED_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |=> ##1 rsp_valid_o); // R2
  end else begin : g_lat_seq
    AST_FIXED_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc |=> ##2 rsp_valid_o); // R2
  end

  AST_DATA_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (((rsp_code_o == RSP_DHIT) || (rsp_code_o == RSP_DMISS)) == op_seen_q)); // R7
  AST_MISS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o != RSP_DHIT) |-> (rsp_ifc_o == '0 && rsp_ptr_o == '0)); // R8
endmodule

bind pit_table pit_table_chk #(.PARALLEL(PARALLEL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_op_i    (cmd_op_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_code_o  (rsp_code_o),
  .rsp_ifc_o   (rsp_ifc_o),
  .rsp_ptr_o   (rsp_ptr_o)
);

// File: tb/pit_table_tb_top.sv
module pit_table_tb_top;
  localparam int LIFE_T = 8;
  localparam logic [2:0] C_INS = 3'd0, C_AGG = 3'd1, C_LOOP = 3'd2,
                         C_FULL = 3'd3, C_DHIT = 3'd4, C_DMISS = 3'd5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_op_i = 1'b0;
  logic [31:0] cmd_sig_i = '0;
  logic [31:0] cmd_ptr_i = '0;
  logic [15:0] cmd_ifc_i = '0;
  logic [15:0] cmd_nonce_i = '0;
  logic        rsp_valid_o;
  logic [2:0]  rsp_code_o;
  logic [15:0] rsp_ifc_o;
  logic [31:0] rsp_ptr_o;

  int tests = 0, fails = 0, tcount = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pit_table #(.IDX_W(4), .LIFE(LIFE_T), .PARALLEL(1'b1)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_op_i(cmd_op_i),
    .cmd_sig_i(cmd_sig_i), .cmd_ptr_i(cmd_ptr_i), .cmd_ifc_i(cmd_ifc_i),
    .cmd_nonce_i(cmd_nonce_i), .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o),
    .rsp_ifc_o(rsp_ifc_o), .rsp_ptr_o(rsp_ptr_o)
  );

  typedef struct packed {
    logic        op;
    logic [31:0] sig;
    logic [15:0] ifc;
    logic [15:0] nonce;
    logic [2:0]  code;
    logic [15:0] rifc;
    logic [3:0]  req;
  } vec_t;

  // index slices with IDX_W=4: way0 = sig[3:0], way1 = sig[7:4]
  localparam vec_t VECS [15] = '{
    '{1'b1, 32'h0000_1011, 16'h0000, 16'h0000, C_DMISS, 16'h0000, 4'd11}, // R11 empty
    '{1'b0, 32'h0000_1011, 16'h0001, 16'h0001, C_INS,   16'h0000, 4'd3},  // R3
    '{1'b0, 32'h0000_1011, 16'h0004, 16'h0002, C_AGG,   16'h0000, 4'd5},  // R5
    '{1'b0, 32'h0000_1011, 16'h0008, 16'h0010, C_LOOP,  16'h0000, 4'd6},  // R6 fold 0x10 -> 1
    '{1'b1, 32'h0000_1011, 16'h0000, 16'h0000, C_DHIT,  16'h0005, 4'd7},  // R7
    '{1'b1, 32'h0000_1011, 16'h0000, 16'h0000, C_DMISS, 16'h0000, 4'd8},  // R8
    '{1'b0, 32'h0000_2022, 16'h0002, 16'h0003, C_INS,   16'h0000, 4'd3},  // R3 way0
    '{1'b0, 32'h0000_3032, 16'h0010, 16'h0003, C_INS,   16'h0000, 4'd3},  // R3 way1
    '{1'b0, 32'h0000_4032, 16'h0040, 16'h0003, C_FULL,  16'h0000, 4'd4},  // R4
    '{1'b1, 32'h0000_4032, 16'h0000, 16'h0000, C_DMISS, 16'h0000, 4'd4},  // R4 not stored
    '{1'b1, 32'hFFFF_3032, 16'h0000, 16'h0000, C_DMISS, 16'h0000, 4'd10}, // R10
    '{1'b1, 32'h0000_3032, 16'h0000, 16'h0000, C_DHIT,  16'h0010, 4'd7},  // R7
    '{1'b0, 32'h0000_4032, 16'h0020, 16'h0005, C_INS,   16'h0000, 4'd3},  // R3 freed way1
    '{1'b1, 32'h0000_4032, 16'h0000, 16'h0000, C_DHIT,  16'h0020, 4'd7},  // R7
    '{1'b1, 32'h0000_2022, 16'h0000, 16'h0000, C_DHIT,  16'h0002, 4'd7}   // R7
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
    tcount += n;
  endtask

  task automatic run(input string req, input logic op, input logic [31:0] sig,
                     input logic [15:0] ifc, input logic [15:0] nonce,
                     input logic [2:0] ecode, input logic [15:0] eifc);
    int lat;
    logic rdy_busy;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_sig_i = sig;
    cmd_ptr_i = ~sig; cmd_ifc_i = ifc; cmd_nonce_i = nonce;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    rdy_busy = cmd_ready_o;
    lat = 1;
    while (!rsp_valid_o && lat < 8) begin
      @(negedge clk_i);
      lat++;
    end
    chk("R1", "ready while busy", 32'(rdy_busy), 32'd0);
    chk("R2", "latency", 32'(lat), 32'd2);
    chk(req, "code", 32'(rsp_code_o), 32'(ecode));
    chk(req, "ifc", 32'(rsp_ifc_o), 32'(eifc));
    chk(req, "ptr", rsp_ptr_o, (ecode == C_DHIT) ? ~sig : 32'd0);
    @(negedge clk_i);
    chk("R2", "pulse", 32'(rsp_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11", "ready in reset", 32'(cmd_ready_o), 32'd1);
    chk("R11", "rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "ready after reset", 32'(cmd_ready_o), 32'd1);

    for (int i = 0; i < 15; i++)
      run($sformatf("R%0d", VECS[i].req), VECS[i].op, VECS[i].sig, VECS[i].ifc,
          VECS[i].nonce, VECS[i].code, VECS[i].rifc);

    // R9 expiry at insert time + LIFE
    run("R9", 1'b0, 32'h0000_5055, 16'h0001, 16'h0001, C_INS, 16'h0000);
    ticks(LIFE_T - 1);
    run("R9", 1'b0, 32'h0000_5055, 16'h0002, 16'h0009, C_AGG, 16'h0000);
    ticks(1);
    run("R9", 1'b1, 32'h0000_5055, 16'h0000, 16'h0000, C_DMISS, 16'h0000);
    run("R9", 1'b0, 32'h0000_5055, 16'h0004, 16'h0001, C_INS, 16'h0000);
    run("R9", 1'b1, 32'h0000_5055, 16'h0000, 16'h0000, C_DHIT, 16'h0004);

    // R9 across counter wrap
    ticks(32'hFFFC - tcount);
    run("R9", 1'b0, 32'h0000_6066, 16'h0100, 16'h0001, C_INS, 16'h0000);
    ticks(LIFE_T - 1);
    run("R9", 1'b0, 32'h0000_6066, 16'h0200, 16'h0002, C_AGG, 16'h0000);
    ticks(1);
    run("R9", 1'b1, 32'h0000_6066, 16'h0000, 16'h0000, C_DMISS, 16'h0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule